// File: doc/BRIEF.md
# CAN Transmit Priority Selector

This block decides which queued transmit message goes to the CAN protocol engine next. It watches two sources. One is a single-slot urgent buffer. The other is the head of the ordinary transmit queue. When the engine is free and at least one source holds a message, the block latches the winning message and raises a one-cycle request. The urgent slot always beats the queue. The latched message stays on the output for the whole attempt.

The block never pre-empts a frame that is already running. A message written to the urgent slot during a frame waits until the engine reports how that frame ended. The source is consumed only after the engine confirms a good completion: the queue gets a pop pulse, or the urgent slot gets a clear pulse. If the frame ends with a bus error or a lost arbitration, nothing is consumed. The selector goes back to idle and chooses again, so a message that arrived in the urgent slot during the failed attempt is sent before the queued message is retried.

The queue storage, the bit-level engine and the register access sit outside this block.

Top module: `can_tx_prio_sel`

## Requirements
- R1: After reset, req_o, fifo_pop_o and hpb_clr_o are all low.
- R2: When both sources are valid and the engine is not busy, the urgent-slot message is the one requested on msg_o.
- R3: When only the queue head is valid and the engine is not busy, the queue head is requested on msg_o.
- R4: req_o is high for exactly one cycle per attempt, and only after a cycle in which eng_busy_i was low.
- R5: req_o rises in the cycle after the first clock edge that sees a valid source with eng_busy_i low. msg_o carries the chosen message in that cycle.
- R6: An urgent message written while a frame is in flight raises no request before that frame ends. During that time msg_o keeps the in-flight message.
- R7: On a good completion (eng_done_i), exactly one single-cycle consume pulse follows in the next cycle: fifo_pop_o for a queued frame, or hpb_clr_o for an urgent frame, never both.
- R8: A frame ending in eng_err_i or eng_arb_lost_i produces no pop and no clear. The same message is requested again two cycles later when the engine is free.
- R9: After a failed queued frame, an urgent message that arrived during the attempt is requested before the queued message is retried.
- R10: When neither source is valid, req_o stays low.
- R11: After a consume pulse, the next request carries the next pending message and never repeats the one just consumed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hpb_valid_i | input | 1 | Urgent slot holds a message |
| hpb_msg_i | input | MSG_W | Urgent slot message |
| fifo_valid_i | input | 1 | Queue is not empty |
| fifo_msg_i | input | MSG_W | Queue head message |
| eng_busy_i | input | 1 | Engine is transmitting |
| eng_done_i | input | 1 | Frame finished successfully (one-cycle pulse) |
| eng_err_i | input | 1 | Frame ended with a bus error (one-cycle pulse) |
| eng_arb_lost_i | input | 1 | Frame lost arbitration (one-cycle pulse) |
| msg_o | output | MSG_W | Message of the current attempt |
| req_o | output | 1 | One-cycle transmit request to the engine |
| fifo_pop_o | output | 1 | Remove the queue head |
| hpb_clr_o | output | 1 | Empty the urgent slot |

## Verification
The hardest case is a failed queued frame during which the urgent slot fills. The queue head must stay in place, and the urgent message must win the retry. The bench reaches this case in a fixed order. It loads the queue and lets the request go out. It holds the engine busy and writes the urgent slot. Then it pulses arbitration lost. It checks that no pop occurred, that the urgent message is requested first, and that the original queue head follows it.

// File: rtl/can_txsel_pkg.sv
package can_txsel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_LAUNCH  = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_RELEASE = 2'd3
  } seq_st_e;

  typedef enum logic {
    SRC_FIFO = 1'b0,
    SRC_HPB  = 1'b1
  } tx_src_e;
endpackage

// File: rtl/txsel_pick.sv
module txsel_pick
  import can_txsel_pkg::*;
#(
  parameter int MSG_W = 32
) (
  input  logic             hpb_valid_i,
  input  logic [MSG_W-1:0] hpb_msg_i,
  input  logic             fifo_valid_i,
  input  logic [MSG_W-1:0] fifo_msg_i,
  output logic             any_o,
  output tx_src_e          src_o,
  output logic [MSG_W-1:0] msg_o
);
  // fixed priority: urgent slot over queue head
  always_comb begin
    any_o = hpb_valid_i | fifo_valid_i;
    if (hpb_valid_i) begin
      src_o = SRC_HPB;
      msg_o = hpb_msg_i;
    end else begin
      src_o = SRC_FIFO;
      msg_o = fifo_msg_i;
    end
  end
endmodule

// File: rtl/txsel_seq.sv
module txsel_seq
  import can_txsel_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_i,
  input  logic eng_busy_i,
  input  logic eng_done_i,
  input  logic eng_err_i,
  input  logic eng_arb_lost_i,
  output logic launch_o,
  output logic req_o,
  output logic rel_o
);
  seq_st_e st_q, st_d;

  assign launch_o = (st_q == ST_IDLE) && any_i && !eng_busy_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (launch_o) st_d = ST_LAUNCH;
      ST_LAUNCH:  st_d = ST_ACTIVE;
      ST_ACTIVE:  begin
        if (eng_done_i)                       st_d = ST_RELEASE;
        else if (eng_err_i || eng_arb_lost_i) st_d = ST_IDLE;  // retry, re-pick
      end
      ST_RELEASE: st_d = ST_IDLE;  // one cycle so source updates before re-pick
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign req_o = (st_q == ST_LAUNCH);
  assign rel_o = (st_q == ST_RELEASE);

  a_r4_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  a_r7_release_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_o |-> $past(eng_done_i));
endmodule

// File: rtl/txsel_hold.sv
module txsel_hold
  import can_txsel_pkg::*;
#(
  parameter int MSG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  tx_src_e          src_i,
  input  logic [MSG_W-1:0] msg_i,
  output tx_src_e          src_o,
  output logic [MSG_W-1:0] msg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o <= SRC_FIFO;
      msg_o <= '0;
    end else if (load_i) begin
      src_o <= src_i;
      msg_o <= msg_i;
    end
  end
endmodule

// File: rtl/can_tx_prio_sel.sv
module can_tx_prio_sel
  import can_txsel_pkg::*;
#(
  parameter int MSG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hpb_valid_i,
  input  logic [MSG_W-1:0] hpb_msg_i,
  input  logic             fifo_valid_i,
  input  logic [MSG_W-1:0] fifo_msg_i,
  input  logic             eng_busy_i,
  input  logic             eng_done_i,
  input  logic             eng_err_i,
  input  logic             eng_arb_lost_i,
  output logic [MSG_W-1:0] msg_o,
  output logic             req_o,
  output logic             fifo_pop_o,
  output logic             hpb_clr_o
);
  logic             any_w, launch_w, rel_w;
  tx_src_e          pick_src_w, cur_src_w;
  logic [MSG_W-1:0] pick_msg_w;

  txsel_pick #(.MSG_W(MSG_W)) u_pick (
    .hpb_valid_i (hpb_valid_i),
    .hpb_msg_i   (hpb_msg_i),
    .fifo_valid_i(fifo_valid_i),
    .fifo_msg_i  (fifo_msg_i),
    .any_o       (any_w),
    .src_o       (pick_src_w),
    .msg_o       (pick_msg_w)
  );

  txsel_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .any_i         (any_w),
    .eng_busy_i    (eng_busy_i),
    .eng_done_i    (eng_done_i),
    .eng_err_i     (eng_err_i),
    .eng_arb_lost_i(eng_arb_lost_i),
    .launch_o      (launch_w),
    .req_o         (req_o),
    .rel_o         (rel_w)
  );

  txsel_hold #(.MSG_W(MSG_W)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(launch_w),
    .src_i (pick_src_w),
    .msg_i (pick_msg_w),
    .src_o (cur_src_w),
    .msg_o (msg_o)
  );

  assign fifo_pop_o = rel_w && (cur_src_w == SRC_FIFO);
  assign hpb_clr_o  = rel_w && (cur_src_w == SRC_HPB);

  a_r4_req_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> !$past(eng_busy_i));
  a_r7_one_consume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_pop_o && hpb_clr_o));
  a_r8_no_consume_on_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(eng_err_i || eng_arb_lost_i) && !$past(eng_done_i)) |-> !(fifo_pop_o || hpb_clr_o));
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hpb_valid_i && !fifo_valid_i) |=> !req_o);
endmodule

// File: tb/sim_can_tx_prio_sel.sv
module sim_can_tx_prio_sel;
  localparam int CLK_P = 10;
  localparam int MSG_W = 32;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [MSG_W-1:0] hpb_msg = '0, msg_o;
  logic eng_busy = 1'b0, eng_done = 1'b0, eng_err = 1'b0, eng_arb = 1'b0;
  logic req_o, fifo_pop_o, hpb_clr_o;

  logic [MSG_W-1:0] fq [8];
  logic [7:0] fq_wr = '0, fq_rd = '0;
  logic [7:0] hb_wr = '0, hb_rd = '0;
  logic fifo_valid, hpb_valid;
  assign fifo_valid = (fq_wr != fq_rd);
  assign hpb_valid  = (hb_wr != hb_rd);

  int checks = 0, errors = 0, cyc = 0;
  bit done_flag = 0;

  always #(CLK_P/2) clk = ~clk;

  can_tx_prio_sel #(.MSG_W(MSG_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .hpb_valid_i(hpb_valid), .hpb_msg_i(hpb_msg),
    .fifo_valid_i(fifo_valid), .fifo_msg_i(fq[fq_rd[2:0]]),
    .eng_busy_i(eng_busy), .eng_done_i(eng_done), .eng_err_i(eng_err),
    .eng_arb_lost_i(eng_arb),
    .msg_o(msg_o), .req_o(req_o), .fifo_pop_o(fifo_pop_o), .hpb_clr_o(hpb_clr_o)
  );

  // queue and urgent slot models consume on the strobes
  always @(posedge clk) begin
    if (fifo_pop_o) fq_rd <= fq_rd + 8'd1;
    if (hpb_clr_o)  hb_rd <= hb_rd + 8'd1;
    cyc <= cyc + 1;
    if (cyc > 20000 && !done_flag) begin
      done_flag = 1;
      errors++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(); @(negedge clk); endtask

  task automatic chk(input bit ok, input string tag, input logic [MSG_W-1:0] act,
                     input logic [MSG_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [MSG_W-1:0] m);
    fq[fq_wr[2:0]] = m;
    fq_wr = fq_wr + 8'd1;
  endtask

  task automatic put_hpb(input logic [MSG_W-1:0] m);
    hpb_msg = m;
    hb_wr = hb_wr + 8'd1;
  endtask

  task automatic expect_req(input logic [MSG_W-1:0] m, input string tag);
    chk(req_o === 1'b1, {tag, " req"}, {31'b0, req_o}, 1);
    chk(msg_o === m, {tag, " msg"}, msg_o, m);
  endtask

  // kind: 0 done, 1 error, 2 arbitration lost; returns where consume pulse is visible
  task automatic finish(input int kind);
    eng_busy = 1'b0;
    eng_done = (kind == 0);
    eng_err  = (kind == 1);
    eng_arb  = (kind == 2);
    step();
    eng_done = 1'b0; eng_err = 1'b0; eng_arb = 1'b0;
  endtask

  task automatic t_reset();
    chk(req_o === 1'b0 && fifo_pop_o === 1'b0 && hpb_clr_o === 1'b0, "R1 reset outs",
        {29'b0, req_o, fifo_pop_o, hpb_clr_o}, 0);
    for (int i = 0; i < 4; i++) begin
      step();
      chk(req_o === 1'b0, "R10 idle no req", {31'b0, req_o}, 0);
    end
  endtask

  task automatic t_fifo_only();
    push(32'hA1);
    step();
    expect_req(32'hA1, "R3 R5 fifo only");
    eng_busy = 1'b1;
    step();
    chk(req_o === 1'b0, "R4 single pulse", {31'b0, req_o}, 0);
    step(); step();
    finish(0);
    chk(fifo_pop_o === 1'b1 && hpb_clr_o === 1'b0, "R7 pop after done",
        {30'b0, fifo_pop_o, hpb_clr_o}, 2);
    step();
    chk(fifo_pop_o === 1'b0, "R7 pop one cycle", {31'b0, fifo_pop_o}, 0);
    for (int i = 0; i < 3; i++) begin
      step();
      chk(req_o === 1'b0, "R10 empty quiet", {31'b0, req_o}, 0);
    end
  endtask

  task automatic t_hpb_first();
    eng_busy = 1'b1;
    push(32'hB2);
    put_hpb(32'hC3);
    for (int i = 0; i < 3; i++) begin
      step();
      chk(req_o === 1'b0, "R4 no req while busy", {31'b0, req_o}, 0);
    end
    eng_busy = 1'b0;
    step();
    expect_req(32'hC3, "R2 urgent first");
    eng_busy = 1'b1;
    step(); step();
    finish(0);
    chk(hpb_clr_o === 1'b1 && fifo_pop_o === 1'b0, "R7 clear after done",
        {30'b0, fifo_pop_o, hpb_clr_o}, 1);
    step(); step();
    expect_req(32'hB2, "R11 next after clear");
    eng_busy = 1'b1;
    step();
    finish(0);
    chk(fifo_pop_o === 1'b1, "R7 pop B2", {31'b0, fifo_pop_o}, 1);
    step(); step(); step();
    chk(req_o === 1'b0, "R11 no repeat", {31'b0, req_o}, 0);
  endtask

  task automatic t_no_abort();
    push(32'hD4);
    step();
    expect_req(32'hD4, "R5 launch D4");
    eng_busy = 1'b1;
    step();
    put_hpb(32'hE5);
    for (int i = 0; i < 4; i++) begin
      step();
      chk(req_o === 1'b0 && msg_o === 32'hD4, "R6 no preempt", msg_o, 32'hD4);
    end
    finish(0);
    chk(fifo_pop_o === 1'b1, "R6 D4 completes", {31'b0, fifo_pop_o}, 1);
    step(); step();
    expect_req(32'hE5, "R6 urgent after frame");
    eng_busy = 1'b1;
    step();
    finish(0);
    chk(hpb_clr_o === 1'b1, "R7 clear E5", {31'b0, hpb_clr_o}, 1);
    step(); step();
  endtask

  task automatic t_retry();
    push(32'hF6);
    step();
    expect_req(32'hF6, "R5 launch F6");
    eng_busy = 1'b1;
    step();
    finish(1);
    chk(fifo_pop_o === 1'b0 && hpb_clr_o === 1'b0 && req_o === 1'b0, "R8 err no pop",
        {30'b0, fifo_pop_o, hpb_clr_o}, 0);
    step();
    expect_req(32'hF6, "R8 retry after err");
    eng_busy = 1'b1;
    step();
    finish(2);
    chk(fifo_pop_o === 1'b0, "R8 arb no pop", {31'b0, fifo_pop_o}, 0);
    step();
    expect_req(32'hF6, "R8 retry after arb");
    eng_busy = 1'b1;
    step();
    finish(0);
    chk(fifo_pop_o === 1'b1, "R8 pop at last", {31'b0, fifo_pop_o}, 1);
    step(); step();
  endtask

  task automatic t_retry_reeval();
    push(32'h17);
    step();
    expect_req(32'h17, "R9 launch 17");
    eng_busy = 1'b1;
    step();
    put_hpb(32'h28);
    step();
    finish(2);
    chk(fifo_pop_o === 1'b0, "R9 no pop on arb", {31'b0, fifo_pop_o}, 0);
    step();
    expect_req(32'h28, "R9 urgent wins retry");
    eng_busy = 1'b1;
    step();
    finish(0);
    chk(hpb_clr_o === 1'b1 && fifo_pop_o === 1'b0, "R9 clear urgent",
        {30'b0, fifo_pop_o, hpb_clr_o}, 1);
    step(); step();
    expect_req(32'h17, "R9 queued retried");
    eng_busy = 1'b1;
    step();
    finish(0);
    chk(fifo_pop_o === 1'b1, "R9 pop 17", {31'b0, fifo_pop_o}, 1);
    step(); step();
  endtask

  initial begin
    step(); step();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_fifo_only();
    t_hpb_first();
    t_no_abort();
    t_retry();
    t_retry_reeval();
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule